// File: doc/BRIEF.md
# Tuning Capacitor Servo Direction Controller

This block chooses the drive direction for the servo motor that turns the variable tuning capacitor of an automatic antenna coupler. Each clock cycle it looks at whether RF power is keyed, at the direction the tuning discriminator asks for, at the two end-of-travel switches on the capacitor, and at two active-low manual frequency requests. From these it produces a two-bit motor command and a flag that enables the tuning logic.

After power-up, and again whenever the capacitor reaches its maximum-capacitance stop, a homing latch drives the capacitor back to minimum. Manual requests let an operator tune with no RF applied. A decrease request forces travel toward maximum capacitance. An increase request passes the discriminator's direction through. The limit switches and manual inputs are asynchronous and mechanical, so each one passes through a synchronizer and a debounce filter of parameterized length. The motor is never commanded further into a stop that is closed.

Top module: `tune_servo_dir`

## Requirements
- R1: While reset is asserted, motor_cmd is 00 and tune_en is 0. The homing latch comes out of reset set, so with the minimum switch open the first command after reset is 01 with tune_en 1.
- R2: When the filtered maximum switch is closed, the homing latch sets. It stays set after that switch opens again, and while it is set and no manual request is active, the command is 01 (toward minimum) even with RF off.
- R3: When the filtered minimum switch is closed, the homing latch clears. This takes priority over setting it.
- R4: One cycle after its inputs, tune_en is 1 exactly when RF is keyed, homing is set, or a manual request is active.
- R5: With RF keyed, homing clear and no manual request, the command follows disc_cmd. A disc_cmd of 01 or 10 passes through, and 00 or 11 gives 00 (hold).
- R6: When man_dec_n is low, the command is 10 (toward maximum) and tune_en is 1 regardless of RF, and this overrides homing.
- R7: When man_inc_n is low and man_dec_n is high, tuning is enabled without RF, the command follows disc_cmd as in R5, and this overrides homing.
- R8: When both manual requests are low, the decrease request wins.
- R9: The command is never 10 while the filtered maximum switch is closed, and never 01 while the filtered minimum switch is closed. A blocked direction becomes 00.
- R10: The command encoding is 00 hold, 01 toward minimum capacitance, 10 toward maximum capacitance, and 11 is never output.
- R11: The lim_max, lim_min, man_inc_n and man_dec_n inputs are synchronized and take effect only after they hold a new level for DEB_CYCLES consecutive sampled cycles. A shorter change has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rf_keyed | input | 1 | RF power present at the antenna input (synchronous) |
| disc_cmd | input | 2 | Discriminator direction request: 00 none, 01 toward min, 10 toward max, 11 invalid |
| lim_max | input | 1 | Maximum-capacitance limit switch, 1 = closed (asynchronous) |
| lim_min | input | 1 | Minimum-capacitance limit switch, 1 = closed (asynchronous) |
| man_inc_n | input | 1 | Manual increase-frequency request, active low (asynchronous) |
| man_dec_n | input | 1 | Manual decrease-frequency request, active low (asynchronous) |
| motor_cmd | output | 2 | Motor command: 00 hold, 01 toward min, 10 toward max |
| tune_en | output | 1 | Tuning-enable flag |

## Verification
Several properties are checked on every cycle: the end-stop blocking, the absence of code 11, the set, hold and clear behaviour of the homing latch, the enable flag, the decrease override, and the rule that a debounced level changes only when its counter expires. Only the bench's scenarios can show the orderings over time. These are the power-up drive to minimum, homing that persists after the maximum switch reopens, an increase request that passes the discriminator through while homing, and short glitches on switches and requests that leave the outputs untouched.

// File: rtl/tsd_pkg.sv
package tsd_pkg;

   typedef enum logic [1:0] {
      MOT_HOLD   = 2'b00,
      MOT_TO_MIN = 2'b01,
      MOT_TO_MAX = 2'b10
   } mot_cmd_e;

   // conditioned-channel indices
   localparam int CH_LMAX  = 0;
   localparam int CH_LMIN  = 1;
   localparam int CH_DEC_N = 2;
   localparam int CH_INC_N = 3;
   localparam int N_CH     = 4;

endpackage

// File: rtl/tsd_sync_debounce.sv
module tsd_sync_debounce #(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 16,
   parameter bit RST_VAL     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic dout
);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("tsd_sync_debounce: SYNC_STAGES must be at least 2");
   end
   if (DEB_CYCLES < 0) begin : g_bad_deb
      $error("tsd_sync_debounce: DEB_CYCLES must not be negative");
   end

   logic [SYNC_STAGES-1:0] sh_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sh_q <= {SYNC_STAGES{RST_VAL}};
      else        sh_q <= {sh_q[SYNC_STAGES-2:0], din};
   end

   logic synced;
   assign synced = sh_q[SYNC_STAGES-1];

   if (DEB_CYCLES == 0) begin : g_no_filter
      assign dout = synced;
   end else begin : g_filter
      localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
      localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYCLES - 1);

      logic [CW-1:0] cnt_q;
      logic          lvl_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt_q <= '0;
            lvl_q <= RST_VAL;
         end else if (synced == lvl_q) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_LAST) begin
            cnt_q <= '0;
            lvl_q <= synced;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end

      assign dout = lvl_q;

      // R11: the filtered level moves only after a full qualifying run
      a_r11_deb_run : assert property (@(posedge clk) disable iff (!rst_n)
         !$stable(lvl_q) |-> ($past(cnt_q) == CNT_LAST));
   end

endmodule

// File: rtl/tsd_home_latch.sv
module tsd_home_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic lim_max_c,
   input  logic lim_min_c,
   output logic home_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         home_q <= 1'b1;
      else if (lim_min_c) home_q <= 1'b0;
      else if (lim_max_c) home_q <= 1'b1;
   end

   a_r2_home_set : assert property (@(posedge clk) disable iff (!rst_n)
      (lim_max_c && !lim_min_c) |=> home_q);

   a_r2_home_keep : assert property (@(posedge clk) disable iff (!rst_n)
      (home_q && !lim_min_c) |=> home_q);

   a_r3_home_clear : assert property (@(posedge clk) disable iff (!rst_n)
      lim_min_c |=> !home_q);

endmodule

// File: rtl/tsd_dir_arbiter.sv
module tsd_dir_arbiter
   import tsd_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rf_keyed,
   input  logic [1:0] disc_cmd,
   input  logic       home_q,
   input  logic       lim_max_c,
   input  logic       lim_min_c,
   input  logic       dec_n_c,
   input  logic       inc_n_c,
   output logic [1:0] cmd_q,
   output logic       tune_en_q
);

   logic     dec_act, inc_act;
   mot_cmd_e auto_dir, want_dir, safe_dir;
   logic     en_nxt;

   always_comb begin
      dec_act = ~dec_n_c;
      inc_act = ~inc_n_c & dec_n_c;

      unique case (disc_cmd)
         2'b01:   auto_dir = MOT_TO_MIN;
         2'b10:   auto_dir = MOT_TO_MAX;
         default: auto_dir = MOT_HOLD;
      endcase

      if (dec_act)       want_dir = MOT_TO_MAX;
      else if (inc_act)  want_dir = auto_dir;
      else if (home_q)   want_dir = MOT_TO_MIN;
      else if (rf_keyed) want_dir = auto_dir;
      else               want_dir = MOT_HOLD;

      safe_dir = want_dir;
      if (want_dir == MOT_TO_MAX && lim_max_c) safe_dir = MOT_HOLD;
      if (want_dir == MOT_TO_MIN && lim_min_c) safe_dir = MOT_HOLD;

      en_nxt = rf_keyed | home_q | dec_act | inc_act;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= MOT_HOLD;
         tune_en_q <= 1'b0;
      end else begin
         cmd_q     <= safe_dir;
         tune_en_q <= en_nxt;
      end
   end

   a_r10_no_code3 : assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q != 2'b11);

   a_r9_max_block : assert property (@(posedge clk) disable iff (!rst_n)
      lim_max_c |=> (cmd_q != MOT_TO_MAX));

   a_r9_min_block : assert property (@(posedge clk) disable iff (!rst_n)
      lim_min_c |=> (cmd_q != MOT_TO_MIN));

   a_r6_dec_drive : assert property (@(posedge clk) disable iff (!rst_n)
      (!dec_n_c && !lim_max_c) |=> (cmd_q == MOT_TO_MAX && tune_en_q));

   a_r4_enable : assert property (@(posedge clk) disable iff (!rst_n)
      (rf_keyed || home_q || !dec_n_c || !inc_n_c) |=> tune_en_q);

endmodule

// File: rtl/tune_servo_dir.sv
module tune_servo_dir
   import tsd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int DEB_CYCLES  = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rf_keyed,
   input  logic [1:0] disc_cmd,
   input  logic       lim_max,
   input  logic       lim_min,
   input  logic       man_inc_n,
   input  logic       man_dec_n,
   output logic [1:0] motor_cmd,
   output logic       tune_en
);

   // idle levels: switches open, requests released
   localparam logic [N_CH-1:0] CH_RST = 4'b1100;

   logic [N_CH-1:0] raw_in, cond;
   logic            home_q;

   assign raw_in[CH_LMAX]  = lim_max;
   assign raw_in[CH_LMIN]  = lim_min;
   assign raw_in[CH_DEC_N] = man_dec_n;
   assign raw_in[CH_INC_N] = man_inc_n;

   for (genvar i = 0; i < N_CH; i++) begin : g_ch
      tsd_sync_debounce #(
         .SYNC_STAGES(SYNC_STAGES),
         .DEB_CYCLES (DEB_CYCLES),
         .RST_VAL    (CH_RST[i])
      ) u_cond (
         .clk  (clk),
         .rst_n(rst_n),
         .din  (raw_in[i]),
         .dout (cond[i])
      );
   end

   tsd_home_latch u_home (
      .clk      (clk),
      .rst_n    (rst_n),
      .lim_max_c(cond[CH_LMAX]),
      .lim_min_c(cond[CH_LMIN]),
      .home_q   (home_q)
   );

   tsd_dir_arbiter u_arb (
      .clk      (clk),
      .rst_n    (rst_n),
      .rf_keyed (rf_keyed),
      .disc_cmd (disc_cmd),
      .home_q   (home_q),
      .lim_max_c(cond[CH_LMAX]),
      .lim_min_c(cond[CH_LMIN]),
      .dec_n_c  (cond[CH_DEC_N]),
      .inc_n_c  (cond[CH_INC_N]),
      .cmd_q    (motor_cmd),
      .tune_en_q(tune_en)
   );

endmodule

// File: tb/tune_servo_dir_test.sv
`timescale 1ns/1ps
module tune_servo_dir_test;

   localparam int DEB    = 4;
   localparam int SETTLE = 16;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rf_keyed = 1'b0;
   logic [1:0] disc_cmd = 2'b00;
   logic       lim_max = 1'b0, lim_min = 1'b0;
   logic       man_inc_n = 1'b1, man_dec_n = 1'b1;
   logic [1:0] motor_cmd;
   logic       tune_en;

   int n_run = 0, n_fail = 0;

   always #5 clk = ~clk;

   tune_servo_dir #(.SYNC_STAGES(2), .DEB_CYCLES(DEB)) uut (
      .clk(clk), .rst_n(rst_n), .rf_keyed(rf_keyed), .disc_cmd(disc_cmd),
      .lim_max(lim_max), .lim_min(lim_min), .man_inc_n(man_inc_n),
      .man_dec_n(man_dec_n), .motor_cmd(motor_cmd), .tune_en(tune_en));

   task automatic cyc(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic expect_out(string req, logic [1:0] ec, logic ee);
      n_run++;
      if (motor_cmd !== ec || tune_en !== ee) begin
         n_fail++;
         $display("FAIL %s: cmd=%b en=%b expected cmd=%b en=%b",
                  req, motor_cmd, tune_en, ec, ee);
      end
   endtask

   task automatic t_reset;
      cyc(3);
      expect_out("R1 in reset", 2'b00, 1'b0);
      rst_n = 1'b1;
      cyc(2);
      expect_out("R1 power-up homing", 2'b01, 1'b1);
      disc_cmd = 2'b10;
      cyc(3);
      expect_out("R2 homing ignores disc with RF off", 2'b01, 1'b1);
   endtask

   task automatic t_home_clear;
      lim_min = 1'b1; cyc(SETTLE);
      expect_out("R3 min stop clears homing, idle hold", 2'b00, 1'b0);
   endtask

   task automatic t_auto;
      rf_keyed = 1'b1; disc_cmd = 2'b10; cyc(2);
      expect_out("R5 auto toward max", 2'b10, 1'b1);
      disc_cmd = 2'b01; cyc(2);
      expect_out("R9 min direction blocked at min stop", 2'b00, 1'b1);
      lim_min = 1'b0; cyc(SETTLE);
      expect_out("R5 auto toward min", 2'b01, 1'b1);
      disc_cmd = 2'b11; cyc(2);
      expect_out("R10 invalid disc gives hold", 2'b00, 1'b1);
      disc_cmd = 2'b00; cyc(2);
      expect_out("R5 no request gives hold", 2'b00, 1'b1);
      rf_keyed = 1'b0; cyc(2);
      expect_out("R4 RF off disables", 2'b00, 1'b0);
   endtask

   task automatic t_max_homing;
      lim_max = 1'b1; cyc(SETTLE);
      expect_out("R2 max stop starts homing", 2'b01, 1'b1);
      lim_max = 1'b0; cyc(SETTLE);
      expect_out("R2 homing persists after max opens", 2'b01, 1'b1);
      man_inc_n = 1'b0; disc_cmd = 2'b10; cyc(SETTLE);
      expect_out("R7 increase overrides homing", 2'b10, 1'b1);
      man_inc_n = 1'b1; disc_cmd = 2'b00; cyc(SETTLE);
      man_dec_n = 1'b0; cyc(SETTLE);
      expect_out("R6 decrease overrides homing", 2'b10, 1'b1);
      man_dec_n = 1'b1; cyc(SETTLE);
      expect_out("R2 homing resumes after decrease", 2'b01, 1'b1);
      lim_min = 1'b1; cyc(SETTLE);
      expect_out("R3 homing ends at min", 2'b00, 1'b0);
      lim_min = 1'b0; cyc(SETTLE);
   endtask

   task automatic t_manual;
      man_dec_n = 1'b0; cyc(SETTLE);
      expect_out("R6 decrease without RF", 2'b10, 1'b1);
      man_dec_n = 1'b1; man_inc_n = 1'b0; disc_cmd = 2'b01; cyc(SETTLE);
      expect_out("R7 increase follows disc min", 2'b01, 1'b1);
      disc_cmd = 2'b10; cyc(2);
      expect_out("R7 increase follows disc max", 2'b10, 1'b1);
      disc_cmd = 2'b00; cyc(2);
      expect_out("R7 increase enables with hold", 2'b00, 1'b1);
      man_dec_n = 1'b0; cyc(SETTLE);
      expect_out("R8 both requests, decrease wins", 2'b10, 1'b1);
      man_dec_n = 1'b1; man_inc_n = 1'b1; cyc(SETTLE);
      expect_out("R4 requests released", 2'b00, 1'b0);
   endtask

   task automatic t_max_block;
      man_dec_n = 1'b0; lim_max = 1'b1; cyc(SETTLE);
      expect_out("R9 max direction blocked at max stop", 2'b00, 1'b1);
      man_dec_n = 1'b1; cyc(SETTLE);
      expect_out("R2 homing from max stop", 2'b01, 1'b1);
      lim_max = 1'b0; lim_min = 1'b1; cyc(SETTLE);
      expect_out("R3 back at min", 2'b00, 1'b0);
   endtask

   task automatic t_glitch;
      logic bad = 1'b0;
      man_dec_n = 1'b0; cyc(2); man_dec_n = 1'b1;
      for (int i = 0; i < SETTLE; i++) begin
         cyc(1);
         if (motor_cmd !== 2'b00 || tune_en !== 1'b0) bad = 1'b1;
      end
      n_run++;
      if (bad) begin
         n_fail++;
         $display("FAIL R11 short decrease pulse: cmd=%b en=%b expected cmd=00 en=0",
                  motor_cmd, tune_en);
      end
      lim_max = 1'b1; cyc(2); lim_max = 1'b0;
      cyc(SETTLE);
      expect_out("R11 short max-stop glitch ignored", 2'b00, 1'b0);
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      @(negedge clk);
      t_reset;
      t_home_clear;
      t_auto;
      t_max_homing;
      t_manual;
      t_max_block;
      t_glitch;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule